// File: doc/BRIEF.md
# Trap Entry Address Generator

This block picks one handler entry point when several trap sources, a floating-point-disabled condition and a pending library-call instruction compete in the same cycle. It holds a programmable, 64-byte-aligned base register. The winning source's offset is added to that base to form the fetch address. The result is registered, so it is presented one clock after the requests.

Eleven external trap lines and one derived floating-point-disabled trap are arbitrated by fixed priority. The lowest index wins. A library call is granted only when no trap is present. Its entry is taken from a privileged region or an unprivileged region, and six bits of its function code select the slot. Each slot is 64 bytes wide. Trap entries are spaced 128 bytes apart.

Top module: `trap_vector_gen`

## Requirements
- R1: While rst_n is low, entryValid is 0, entryGrant is all zero and entryAddr is zero. The base register also clears, so the first trap after reset with index k yields address k*0x80.
- R2: Requests sampled at a rising clock edge appear on the outputs right after that edge, which is one cycle of latency. entryValid is high for exactly the cycles that follow a cycle with a request.
- R3: The twelve trap sources are numbered 0 to 11. Index 0 is the highest priority and index 11 is the floating-point-disabled trap. When several are active, the lowest active index wins and entryGrant has only bit k set. Index 0 overrides everything else, including calls.
- R4: A granted trap with index k produces entryAddr = base + k*0x80.
- R5: The floating-point-disabled trap (index 11) is raised when fpOpValid is high while fpEnable is low.
- R6: The floating-point-disabled trap is also raised when ieeeOpValid is high and ieeeFmt is 3. The ieeeFmt codes are 0 for single, 1 for double and 2 for quadword integer. Codes 0 to 2 raise nothing.
- R7: When no trap is active and callValid is high, grant bit 12 is set. entryAddr = base + 0x2000 + callFunc[5:0]*0x40 if callPriv is 1, and base + 0x3000 + callFunc[5:0]*0x40 if callPriv is 0. Function bits above bit 5 have no effect.
- R8: When baseWe is high at an edge, the base register loads baseWrData with bits [5:0] forced to zero. Only requests from the next cycle onward use the new base. A request in the same cycle as the write uses the old base.
- R9: With no trap, no floating-point-disabled condition and no call, entryValid is 0 and entryGrant is zero in the next cycle. entryAddr keeps its previous value.
- R10: entryGrant has at most one bit set. entryValid is high exactly when entryGrant is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trapReq | input | 11 | Trap request lines, index 0 highest priority |
| fpOpValid | input | 1 | A floating-point load, store or operate is attempted |
| fpEnable | input | 1 | Floating-point enable control bit |
| ieeeOpValid | input | 1 | An IEEE floating-point operation is attempted |
| ieeeFmt | input | 2 | Data type of that operation: 0 single, 1 double, 2 quadword, 3 other |
| callValid | input | 1 | A library-call instruction is pending |
| callPriv | input | 1 | 1 = privileged call region, 0 = unprivileged region |
| callFunc | input | FUNC_W | Function code of the call |
| baseWe | input | 1 | Base register write strobe |
| baseWrData | input | ADDR_W | Value for the base register |
| entryValid | output | 1 | An entry address is presented |
| entryGrant | output | 13 | One-hot winner: bits 0-11 traps, bit 12 call |
| entryAddr | output | ADDR_W | Selected handler entry address |

## Verification
Single traps are driven one at a time to tie each index to its 128-byte offset. Pairs and full-vector bursts show that the lowest index wins and not some other order. Both floating-point-disabled conditions are driven on their own and against higher traps, and every ieeeFmt code is tried, which separates the one illegal data type from the legal ones. Calls are issued in both regions with high function bits set. A base write is placed in the same cycle as a request to expose the one-cycle take-up of the new base. A long run of seeded random mixes then compares every output against the bench's model.

// File: rtl/tv_pkg.sv
package tv_pkg;
  // Number of externally requested trap sources.
  localparam int EXT_TRAPS   = 11;
  // All trap sources, including the derived floating-point-disabled trap.
  localparam int TRAP_COUNT  = EXT_TRAPS + 1;
  // Grant vector width: every trap plus the call slot.
  localparam int GRANT_W     = TRAP_COUNT + 1;
  localparam int IDX_W       = $clog2(TRAP_COUNT);
  localparam int FP_DIS_IDX  = TRAP_COUNT - 1;
  localparam int CALL_BIT    = TRAP_COUNT;

  // Call slot selection and spacing.
  localparam int CALL_SEL_W  = 6;
  localparam int CALL_SHIFT  = 6;
  localparam int TRAP_SHIFT  = 7;
  localparam int ALIGN_LOG2  = 6;
  localparam int PRIV_REGION = 'h2000;
  localparam int USER_REGION = 'h3000;

  // IEEE data type codes.
  typedef enum logic [1:0] {
    FMT_SINGLE = 2'd0,
    FMT_DOUBLE = 2'd1,
    FMT_QUAD   = 2'd2,
    FMT_OTHER  = 2'd3
  } ieeeFmt_e;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic                  fire;
    logic                  isCall;
    logic                  callPriv;
    logic [IDX_W-1:0]      trapIdx;
    logic [CALL_SEL_W-1:0] callSel;
    logic [GRANT_W-1:0]    grant;
  } vecStrobe_t;
endpackage

// File: rtl/tv_arbiter.sv
module tv_arbiter
  import tv_pkg::*;
#(
  parameter int FUNC_W = 26
) (
  input  logic [EXT_TRAPS-1:0] trapReq,
  input  logic                 fpOpValid,
  input  logic                 fpEnable,
  input  logic                 ieeeOpValid,
  input  logic [1:0]           ieeeFmt,
  input  logic                 callValid,
  input  logic                 callPriv,
  input  logic [FUNC_W-1:0]    callFunc,
  output vecStrobe_t           strobe
);
  logic                  fpDisabledHit;
  logic [TRAP_COUNT-1:0] allReq;
  logic                  anyTrap;
  logic [IDX_W-1:0]      winIdx;

  // The floating-point-disabled trap comes from two separate conditions.
  always_comb begin
    fpDisabledHit = (fpOpValid && !fpEnable) ||
                    (ieeeOpValid && (ieeeFmt_e'(ieeeFmt) == FMT_OTHER));
    allReq        = {fpDisabledHit, trapReq};
    anyTrap       = |allReq;
  end

  // Fixed priority. The scan runs from low priority to high, so the
  // lowest active index is the last one written and wins.
  always_comb begin
    winIdx = '0;
    for (int i = TRAP_COUNT - 1; i >= 0; i--) begin
      if (allReq[i]) winIdx = IDX_W'(i);
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.callPriv = callPriv;
    strobe.callSel  = callFunc[CALL_SEL_W-1:0];
    strobe.trapIdx  = winIdx;
    if (anyTrap) begin
      strobe.fire          = 1'b1;
      strobe.grant[winIdx] = 1'b1;
    end else if (callValid) begin
      strobe.fire             = 1'b1;
      strobe.isCall           = 1'b1;
      strobe.grant[CALL_BIT]  = 1'b1;
    end
  end
endmodule

// File: rtl/tv_vecpath.sv
module tv_vecpath
  import tv_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  vecStrobe_t         strobe,
  input  logic               baseWe,
  input  logic [ADDR_W-1:0]  baseWrData,
  output logic               entryValid,
  output logic [GRANT_W-1:0] entryGrant,
  output logic [ADDR_W-1:0]  entryAddr
);
  localparam logic [ADDR_W-1:0] PRIV_OFS = ADDR_W'(PRIV_REGION);
  localparam logic [ADDR_W-1:0] USER_OFS = ADDR_W'(USER_REGION);

  logic [ADDR_W-1:0] baseReg;
  logic [ADDR_W-1:0] baseAligned;
  logic [ADDR_W-1:0] trapOfs;
  logic [ADDR_W-1:0] callOfs;
  logic [ADDR_W-1:0] nextAddr;

  // Force the low bits of a written base to zero.
  generate
    if (ALIGN_LOG2 > 0) begin : g_align
      assign baseAligned = {baseWrData[ADDR_W-1:ALIGN_LOG2], {ALIGN_LOG2{1'b0}}};
    end else begin : g_noalign
      assign baseAligned = baseWrData;
    end
  endgenerate

  always_comb begin
    trapOfs  = ADDR_W'(strobe.trapIdx) << TRAP_SHIFT;
    callOfs  = (strobe.callPriv ? PRIV_OFS : USER_OFS) +
               (ADDR_W'(strobe.callSel) << CALL_SHIFT);
    nextAddr = baseReg + (strobe.isCall ? callOfs : trapOfs);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseReg <= '0;
    end else if (baseWe) begin
      baseReg <= baseAligned;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entryValid <= 1'b0;
      entryGrant <= '0;
      entryAddr  <= '0;
    end else begin
      entryValid <= strobe.fire;
      entryGrant <= strobe.grant;
      if (strobe.fire) entryAddr <= nextAddr;
    end
  end
endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
  import tv_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int FUNC_W = 26
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [EXT_TRAPS-1:0] trapReq,
  input  logic                 fpOpValid,
  input  logic                 fpEnable,
  input  logic                 ieeeOpValid,
  input  logic [1:0]           ieeeFmt,
  input  logic                 callValid,
  input  logic                 callPriv,
  input  logic [FUNC_W-1:0]    callFunc,
  input  logic                 baseWe,
  input  logic [ADDR_W-1:0]    baseWrData,
  output logic                 entryValid,
  output logic [GRANT_W-1:0]   entryGrant,
  output logic [ADDR_W-1:0]    entryAddr
);
  vecStrobe_t strobe;

  tv_arbiter #(.FUNC_W(FUNC_W)) u_arb (
    .trapReq     (trapReq),
    .fpOpValid   (fpOpValid),
    .fpEnable    (fpEnable),
    .ieeeOpValid (ieeeOpValid),
    .ieeeFmt     (ieeeFmt),
    .callValid   (callValid),
    .callPriv    (callPriv),
    .callFunc    (callFunc),
    .strobe      (strobe)
  );

  tv_vecpath #(.ADDR_W(ADDR_W)) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .baseWe     (baseWe),
    .baseWrData (baseWrData),
    .entryValid (entryValid),
    .entryGrant (entryGrant),
    .entryAddr  (entryAddr)
  );
endmodule

// File: rtl/tv_checker.sv
module tv_checker
  import tv_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [EXT_TRAPS-1:0] trapReq,
  input logic                 fpOpValid,
  input logic                 fpEnable,
  input logic                 ieeeOpValid,
  input logic                 callValid,
  input logic                 entryValid,
  input logic [GRANT_W-1:0]   entryGrant,
  input logic [ADDR_W-1:0]    entryAddr
);
  p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(entryGrant));

  p_valid_matches_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    entryValid == (entryGrant != '0));

  p_top_source_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trapReq[0] |=> entryGrant[0]);

  p_request_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trapReq != '0) |=> entryValid);

  p_fp_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fpOpValid && !fpEnable && trapReq == '0) |=> entryGrant[FP_DIS_IDX]);

  p_call_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (callValid && trapReq == '0 && !fpOpValid && !ieeeOpValid) |=> entryGrant[CALL_BIT]);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trapReq == '0 && !fpOpValid && !ieeeOpValid && !callValid) |=>
      (!entryValid && $stable(entryAddr)));

  p_addr_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    entryAddr[ALIGN_LOG2-1:0] == '0);
endmodule

bind trap_vector_gen tv_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trapReq     (trapReq),
  .fpOpValid   (fpOpValid),
  .fpEnable    (fpEnable),
  .ieeeOpValid (ieeeOpValid),
  .callValid   (callValid),
  .entryValid  (entryValid),
  .entryGrant  (entryGrant),
  .entryAddr   (entryAddr)
);

// File: tb/test_trap_vector_gen.sv
module test_trap_vector_gen;
  import tv_pkg::*;
  localparam int ADDR_W = 40;
  localparam int FUNC_W = 26;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                 rst_n;
  logic [EXT_TRAPS-1:0] trapReq;
  logic                 fpOpValid, fpEnable, ieeeOpValid;
  logic [1:0]           ieeeFmt;
  logic                 callValid, callPriv;
  logic [FUNC_W-1:0]    callFunc;
  logic                 baseWe;
  logic [ADDR_W-1:0]    baseWrData;
  logic                 entryValid;
  logic [GRANT_W-1:0]   entryGrant;
  logic [ADDR_W-1:0]    entryAddr;

  trap_vector_gen #(.ADDR_W(ADDR_W), .FUNC_W(FUNC_W)) i_trap_vector_gen (.*);

  int total = 0;
  int bad   = 0;
  logic [ADDR_W-1:0]  modelBase = '0;
  logic [ADDR_W-1:0]  expAddr   = '0;
  logic               expValid;
  logic [GRANT_W-1:0] expGrant;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic clearIn();
    trapReq = '0; fpOpValid = 0; fpEnable = 1; ieeeOpValid = 0; ieeeFmt = 0;
    callValid = 0; callPriv = 0; callFunc = '0; baseWe = 0; baseWrData = '0;
  endtask

  // Model built from the requirements: priority (R3), offsets (R4, R7),
  // floating-point-disabled conditions (R5, R6), base take-up (R8), hold (R9).
  task automatic step(string tag);
    logic fen;
    logic [TRAP_COUNT-1:0] all;
    int idx;
    fen = (fpOpValid && !fpEnable) || (ieeeOpValid && ieeeFmt == 2'd3);
    all = {fen, trapReq};
    idx = 0;
    expValid = 0; expGrant = '0;
    for (int i = TRAP_COUNT - 1; i >= 0; i--) if (all[i]) idx = i;
    if (all != '0) begin
      expValid = 1; expGrant[idx] = 1'b1;
      expAddr = modelBase + (ADDR_W'(idx) << 7);
    end else if (callValid) begin
      expValid = 1; expGrant[TRAP_COUNT] = 1'b1;
      expAddr = modelBase + (callPriv ? ADDR_W'('h2000) : ADDR_W'('h3000)) +
                (ADDR_W'(callFunc[5:0]) << 6);
    end
    @(posedge clk);
    if (baseWe) modelBase = {baseWrData[ADDR_W-1:6], 6'b0};
    @(negedge clk);
    check(tag, "valid", 64'(entryValid), 64'(expValid));
    check(tag, "grant", 64'(entryGrant), 64'(expGrant));
    check(tag, "addr",  64'(entryAddr),  64'(expAddr));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    clearIn();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", "valid", 64'(entryValid), 64'd0);
    check("R1", "grant", 64'(entryGrant), 64'd0);
    check("R1", "addr",  64'(entryAddr),  64'd0);
    rst_n = 1;

    // R1: base cleared, first trap at index*0x80
    trapReq = 11'b100; step("R1");
    clearIn(); step("R9");

    // R4: each single trap at its offset
    for (int k = 0; k < EXT_TRAPS; k++) begin
      clearIn(); trapReq = 11'(1) << k; step("R4");
    end

    // R3: pairs and a full burst
    clearIn(); trapReq = 11'b100_0010_0000; step("R3");
    clearIn(); trapReq = '1; callValid = 1; fpOpValid = 1; fpEnable = 0; step("R3");
    clearIn(); trapReq = 11'b000_0000_0001; callValid = 1; step("R3");

    // R5: FP op with enable clear vs set
    clearIn(); fpOpValid = 1; fpEnable = 0; step("R5");
    clearIn(); fpOpValid = 1; fpEnable = 1; callValid = 1; callPriv = 1; step("R5");
    clearIn(); fpOpValid = 1; fpEnable = 0; trapReq = 11'b100_0000_0000; step("R5");

    // R6: every data type code
    for (int f = 0; f < 4; f++) begin
      clearIn(); ieeeOpValid = 1; ieeeFmt = 2'(f); callValid = 1; step("R6");
    end

    // R7: calls in both regions, high function bits set
    clearIn(); callValid = 1; callPriv = 1; callFunc = 26'h3FF_FFC5; step("R7");
    clearIn(); callValid = 1; callPriv = 0; callFunc = 26'h200_003F; step("R7");
    clearIn(); callValid = 1; callPriv = 0; callFunc = 26'h0; step("R7");

    // R8: write with concurrent request uses old base, next uses new
    clearIn(); baseWe = 1; baseWrData = 40'hAB_CDEF_12FF; trapReq = 11'b10; step("R8");
    clearIn(); trapReq = 11'b10; step("R8");
    clearIn(); callValid = 1; callPriv = 1; callFunc = 26'h7; step("R8");

    // R9: idle holds the address, R2: one-cycle valid pulse
    clearIn(); step("R9");
    clearIn(); step("R2");

    // R10 and mixed: seeded random traffic
    for (int n = 0; n < 3000; n++) begin
      clearIn();
      if ($urandom % 3 == 0) trapReq = 11'($urandom) & 11'($urandom) & 11'($urandom);
      fpOpValid   = ($urandom % 8) == 0;
      fpEnable    = ($urandom % 2) == 0;
      ieeeOpValid = ($urandom % 8) == 0;
      ieeeFmt     = 2'($urandom);
      callValid   = ($urandom % 2) == 0;
      callPriv    = ($urandom % 2) == 0;
      callFunc    = 26'($urandom);
      baseWe      = ($urandom % 16) == 0;
      baseWrData  = {8'($urandom), 32'($urandom)};
      step("R10");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule